// File: doc/BRIEF.md
# Frame Trigger and Flash Strobe Sequencer

This block paces frame capture for an image sensor. It watches two trigger sources, a pin wired from outside and a level driven by the host link, and, once the selected source rises, runs one frame: a programmable wait, an integration window, and a single-cycle request to start readout. While this runs it drives a strobe for flash lighting. The strobe either follows the start of integration by a programmed lag or leads it by a programmed lead. When the lead is nonzero it wins and the lag is not used. An optional duration setting limits how long the strobe stays on.

Two bits choose the source and the repeat behaviour. In single-frame operation each rising edge gives exactly one frame. In repeating operation frames follow one another for as long as the chosen source stays high, with a programmed gap between them. All timing counts in ticks from two prescalers that divide the system clock: a slow tick for the trigger wait, integration, strobe lag, strobe lead and strobe width, and a fast tick for the gap between repeated frames. Settings are captured at the start of each frame.

Top module: `trig_strobe_seq`

## Requirements
- R1: `mode[1]` selects the source (0 = `trig_pin`, 1 = `trig_host`) and `mode[0]` selects repeating operation (1) over single-frame operation (0). A rising edge on the source that is not selected starts no frame.
- R2: After a rising edge on the selected source, `integrate` rises `trig_delay*DIV_SLOW+1` cycles after the wait begins, and stays high for exactly `integ_time*DIV_SLOW+1` cycles.
- R3: In single-frame operation one rising edge yields exactly one frame, even when the source is held high afterwards.
- R4: A rising edge that arrives while a frame is in progress is ignored and adds no frame.
- R5: `readout_start` is high for exactly one cycle, and that cycle is the first cycle in which `integrate` is low again.
- R6: With `strb_adv` = 0, `strobe` rises `strb_delay*DIV_SLOW+1` cycles after `integrate` rises and stays on through the readout cycle. If `strb_delay` exceeds `integ_time`, no strobe appears. The strobe is never high in the cycle after `readout_start`.
- R7: With `strb_adv` nonzero, `strobe_delay` is ignored and `strobe` rises `min(strb_adv, trig_delay)*DIV_SLOW` cycles before `integrate` rises. It then stays on until the readout cycle.
- R8: With `strb_dur_en` = 1, the strobe lasts `min(strb_dur*DIV_SLOW+1, unlimited width)` cycles.
- R9: In repeating operation, while the source stays high, frames repeat, and the count of low cycles of `integrate` between frames is `retrig_delay*DIV_FAST + trig_delay*DIV_SLOW + 3`. Once the source is low at the end of a frame, or at the end of the gap, no further frame follows.
- R10: In reset, `integrate`, `readout_start` and `strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Trigger from the external connector, asynchronous |
| trig_host | input | 1 | Trigger level set through the host link, asynchronous |
| mode | input | 2 | Bit 1 selects the source, bit 0 selects repeating operation |
| trig_delay | input | 16 | Wait from trigger to integration, in slow ticks |
| integ_time | input | 16 | Integration length, in slow ticks |
| strb_delay | input | 16 | Strobe lag after integration start, in slow ticks |
| strb_adv | input | 16 | Strobe lead before integration start, in slow ticks; nonzero takes priority |
| strb_dur_en | input | 1 | Limit the strobe width to `strb_dur` |
| strb_dur | input | 16 | Strobe width limit, in slow ticks |
| retrig_delay | input | 16 | Gap between repeated frames, in fast ticks |
| integrate | output | 1 | Sensor integration window |
| readout_start | output | 1 | One-cycle request to start readout |
| strobe | output | 1 | Flash strobe |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one frame. It appears as an integration window of the wrong length, a missing or doubled `readout_start`, or an extra frame after a one-shot edge. A prescaler or tick counter that starts out of phase moves the edges of `integrate` and `strobe` by whole ticks, so each frame is scored on the cycle counts of integration width, strobe offset, strobe width and the gap between frames. A wrongly latched strobe mode turns a lead into a lag, so the offset changes sign, and it shows in the very first frame.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int unsigned CNT_W = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TDLY,
        S_INTEG,
        S_RDOUT,
        S_RWAIT
    } seq_state_e;

    typedef struct packed {
        logic             src;
        logic             retrig;
        logic [CNT_W-1:0] ilen;
        logic [CNT_W-1:0] sdly;
        logic [CNT_W-1:0] sadv;
        logic             dur_en;
        logic [CNT_W-1:0] sdur;
        logic [CNT_W-1:0] rdly;
    } frame_cfg_t;

    // true once at least dly ticks of an ilen-tick window have elapsed
    function automatic logic lag_reached(input logic [CNT_W-1:0] remain,
                                         input logic [CNT_W-1:0] ilen,
                                         input logic [CNT_W-1:0] dly);
        logic [CNT_W:0] sum;
        sum = {1'b0, remain} + {1'b0, dly};
        return (dly <= ilen) && (sum <= {1'b0, ilen});
    endfunction

endpackage

// File: rtl/tsq_tick.sv
module tsq_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_count
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pc_q;
            always_ff @(posedge clk) begin
                if (rst || clr || pc_q == LAST) pc_q <= '0;
                else                            pc_q <= pc_q + 1'b1;
            end
            assign tick = (pc_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tsq_sync.sv
module tsq_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end
    assign lvl  = s2_q;
    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tsq_strobe.sv
module tsq_strobe
    import tsq_pkg::*;
#(
    parameter int unsigned DIV = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             window,
    input  logic             dur_en,
    input  logic [CNT_W-1:0] dur,
    output logic             strobe
);
    logic             on_q, used_q, tick;
    logic [CNT_W-1:0] dcnt_q;

    tsq_tick #(.DIV(DIV)) u_wtick (
        .clk  (clk),
        .rst  (rst),
        .clr  (!on_q),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !window) begin
            on_q   <= 1'b0;
            used_q <= 1'b0;
            dcnt_q <= '0;
        end else if (!used_q) begin
            on_q   <= 1'b1;
            used_q <= 1'b1;
            dcnt_q <= dur;
        end else if (on_q && dur_en && dcnt_q == '0) begin
            on_q <= 1'b0;
        end else if (on_q && tick && dcnt_q != '0) begin
            dcnt_q <= dcnt_q - 1'b1;
        end
    end

    assign strobe = on_q;
endmodule

// File: rtl/trig_strobe_seq.sv
module trig_strobe_seq
    import tsq_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 1000,
    parameter int unsigned DIV_FAST = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_pin,
    input  logic             trig_host,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] trig_delay,
    input  logic [CNT_W-1:0] integ_time,
    input  logic [CNT_W-1:0] strb_delay,
    input  logic [CNT_W-1:0] strb_adv,
    input  logic             strb_dur_en,
    input  logic [CNT_W-1:0] strb_dur,
    input  logic [CNT_W-1:0] retrig_delay,
    output logic             integrate,
    output logic             readout_start,
    output logic             strobe
);
    localparam int unsigned NSRC = 2;

    logic [NSRC-1:0]  lvl, rise;
    seq_state_e       st_q, st_d;
    frame_cfg_t       cfg_q, cfg_live;
    logic [CNT_W-1:0] cnt_q, cnt_ld;
    logic             clr, tick_s, tick_f, tick, done, latch, window, src_hi;

    tsq_sync #(.W(NSRC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({trig_host, trig_pin}),
        .lvl  (lvl),
        .rise (rise)
    );

    tsq_tick #(.DIV(DIV_SLOW)) u_slow (.clk(clk), .rst(rst), .clr(clr), .tick(tick_s));
    tsq_tick #(.DIV(DIV_FAST)) u_fast (.clk(clk), .rst(rst), .clr(clr), .tick(tick_f));

    always_comb begin
        cfg_live = '{src: mode[1], retrig: mode[0], ilen: integ_time,
                     sdly: strb_delay, sadv: strb_adv, dur_en: strb_dur_en,
                     sdur: strb_dur, rdly: retrig_delay};
    end

    assign done   = (cnt_q == '0);
    assign src_hi = lvl[cfg_q.src];
    assign tick   = (st_q == S_RWAIT) ? tick_f : tick_s;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (rise[mode[1]]) st_d = S_TDLY;
            S_TDLY:  if (done) st_d = S_INTEG;
            S_INTEG: if (done) st_d = S_RDOUT;
            S_RDOUT: st_d = (cfg_q.retrig && src_hi) ? S_RWAIT : S_IDLE;
            S_RWAIT: if (done) st_d = src_hi ? S_TDLY : S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    assign clr   = (st_d != st_q);
    assign latch = (st_d == S_TDLY) && (st_q != S_TDLY);

    always_comb begin
        unique case (st_d)
            S_TDLY:  cnt_ld = trig_delay;
            S_INTEG: cnt_ld = cfg_q.ilen;
            S_RWAIT: cnt_ld = cfg_q.rdly;
            default: cnt_ld = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            cfg_q <= '0;
        end else begin
            st_q <= st_d;
            if (latch) cfg_q <= cfg_live;
            if (clr)                cnt_q <= cnt_ld;
            else if (tick && !done) cnt_q <= cnt_q - 1'b1;
        end
    end

    // strobe window: lead takes priority over lag
    always_comb begin
        if (cfg_q.sadv != '0)
            window = (st_q == S_INTEG) || (st_q == S_TDLY && cnt_q <= cfg_q.sadv);
        else
            window = (st_q == S_INTEG) && lag_reached(cnt_q, cfg_q.ilen, cfg_q.sdly);
    end

    tsq_strobe #(.DIV(DIV_SLOW)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .window (window),
        .dur_en (cfg_q.dur_en),
        .dur    (cfg_q.sdur),
        .strobe (strobe)
    );

    assign integrate     = (st_q == S_INTEG);
    assign readout_start = (st_q == S_RDOUT);
endmodule

// File: rtl/tsq_sva.sv
module tsq_sva
    import tsq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       integrate,
    input logic       readout_start,
    input logic       strobe,
    input seq_state_e st,
    input logic       retrig
);
    a_r5_readout_single: assert property (@(posedge clk) disable iff (rst)
        readout_start |=> !readout_start);

    a_r5_readout_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(integrate) |-> readout_start);

    a_r6_strobe_bounded: assert property (@(posedge clk) disable iff (rst)
        $past(readout_start) |-> !strobe);

    a_r2_integ_after_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(integrate) |-> $past(st) == S_TDLY);

    a_r9_gap_needs_repeat: assert property (@(posedge clk) disable iff (rst)
        st == S_RWAIT |-> retrig);

    a_r5_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({integrate, readout_start}));
endmodule

bind trig_strobe_seq tsq_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .integrate     (integrate),
    .readout_start (readout_start),
    .strobe        (strobe),
    .st            (st_q),
    .retrig        (cfg_q.retrig)
);

// File: tb/tb_trig_strobe_seq.sv
module tb_trig_strobe_seq;
    localparam int DS = 4;
    localparam int DF = 2;

    typedef struct {
        int iw;
        int soff;
        int sw;
        bit hs;
        int gap;
    } frame_exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_pin = 1'b0, trig_host = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [15:0] trig_delay = '0, integ_time = '0, strb_delay = '0, strb_adv = '0;
    logic [15:0] strb_dur = '0, retrig_delay = '0;
    logic strb_dur_en = 1'b0;
    logic integrate, readout_start, strobe;

    always #4 clk = ~clk;

    trig_strobe_seq #(.DIV_SLOW(DS), .DIV_FAST(DF)) dut (
        .clk(clk), .rst(rst), .trig_pin(trig_pin), .trig_host(trig_host),
        .mode(mode), .trig_delay(trig_delay), .integ_time(integ_time),
        .strb_delay(strb_delay), .strb_adv(strb_adv), .strb_dur_en(strb_dur_en),
        .strb_dur(strb_dur), .retrig_delay(retrig_delay),
        .integrate(integrate), .readout_start(readout_start), .strobe(strobe)
    );

    int checks = 0, fails = 0, frames = 0;
    frame_exp_t exp_q[$];
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // driver: push the expected frame
    task automatic expect_frame(input int iw, input int soff, input int sw,
                                input bit hs, input int gap);
        frame_exp_t e;
        e.iw = iw; e.soff = soff; e.sw = sw; e.hs = hs; e.gap = gap;
        exp_q.push_back(e);
    endtask

    task automatic cfg(input logic [1:0] m, input int n, input int l, input int d,
                       input int a, input bit den, input int w, input int r);
        @(posedge clk); #1;
        mode = m; trig_delay = 16'(n); integ_time = 16'(l); strb_delay = 16'(d);
        strb_adv = 16'(a); strb_dur_en = den; strb_dur = 16'(w); retrig_delay = 16'(r);
    endtask

    task automatic pulse_pin(input int len);
        @(posedge clk); #1 trig_pin = 1'b1;
        repeat (len) @(posedge clk);
        #1 trig_pin = 1'b0;
    endtask

    task automatic pulse_host(input int len);
        @(posedge clk); #1 trig_host = 1'b1;
        repeat (len) @(posedge clk);
        #1 trig_host = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // monitor: measure each frame and compare against the queue
    int  cyc = 0, int_rise = 0, int_fall = 0, str_rise = 0, str_fall = 0, rd_c = 0, prev_fall = 0;
    bit  p_int = 0, p_str = 0, p_rd = 0, str_seen = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            p_int = 0; p_str = 0; p_rd = 0; str_seen = 0;
        end else begin
            if (integrate && !p_int) int_rise = cyc;
            if (!integrate && p_int) int_fall = cyc;
            if (strobe && !p_str) begin str_rise = cyc; str_seen = 1; end
            if (!strobe && p_str) str_fall = cyc;
            if (readout_start && !p_rd) rd_c = cyc;
            if (readout_start && p_rd) chk(0, "R5 readout width", 2, 1);
            if (p_rd && !readout_start) begin
                frames++;
                if (exp_q.size() == 0) begin
                    chk(0, "R3/R4 unexpected frame", frames, frames - 1);
                end else begin
                    frame_exp_t e;
                    e = exp_q.pop_front();
                    chk(int_fall - int_rise == e.iw, "R2 integrate width", int_fall - int_rise, e.iw);
                    chk(rd_c == int_fall, "R5 readout position", rd_c, int_fall);
                    chk(str_seen == e.hs, "R6 strobe present", int'(str_seen), int'(e.hs));
                    if (e.hs && str_seen) begin
                        chk(str_rise - int_rise == e.soff, "R6/R7 strobe offset",
                            str_rise - int_rise, e.soff);
                        chk(str_fall - str_rise == e.sw, "R6/R7/R8 strobe width",
                            str_fall - str_rise, e.sw);
                    end
                    if (e.gap >= 0)
                        chk(int_rise - prev_fall == e.gap, "R9 frame gap",
                            int_rise - prev_fall, e.gap);
                end
                prev_fall = int_fall;
                str_seen = 0;
            end
            p_int = integrate; p_str = strobe; p_rd = readout_start;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int base;
        settle(3);
        #1;
        chk(!integrate && !readout_start && !strobe, "R10 reset outputs",
            int'({integrate, readout_start, strobe}), 0);
        settle(2); #1 rst = 1'b0;

        // R1 R2 R3 R6: pin one-shot, lag strobe; host edge ignored; held level gives one frame
        cfg(2'b00, 2, 3, 1, 0, 0, 0, 0);
        expect_frame(3*DS+1, 1*DS+1, (3-1)*DS+1, 1, -1);
        base = frames;
        pulse_pin(200);
        settle(100);
        chk(frames == base + 1, "R3 one frame while held", frames, base + 1);
        pulse_host(5);
        settle(150);
        chk(frames == base + 1, "R1 unselected source ignored", frames, base + 1);

        // R4: edge during a frame is ignored
        expect_frame(3*DS+1, 1*DS+1, (3-1)*DS+1, 1, -1);
        base = frames;
        pulse_pin(4);
        wait (integrate == 1'b1);
        pulse_pin(4);
        settle(150);
        chk(frames == base + 1, "R4 edge in frame ignored", frames, base + 1);

        // R6: lag longer than integration gives no strobe
        cfg(2'b00, 1, 3, 5, 0, 0, 0, 0);
        expect_frame(3*DS+1, 0, 0, 0, -1);
        pulse_pin(4); settle(150);

        // R7: lead takes priority over lag
        cfg(2'b00, 3, 3, 2, 1, 0, 0, 0);
        expect_frame(3*DS+1, -(1*DS), (1*DS+1) + (3*DS+1), 1, -1);
        pulse_pin(4); settle(150);

        // R7: lead larger than the trigger wait is clipped to it
        cfg(2'b00, 2, 3, 0, 5, 0, 0, 0);
        expect_frame(3*DS+1, -(2*DS), (2*DS+1) + (3*DS+1), 1, -1);
        pulse_pin(4); settle(150);

        // R8: duration limit
        cfg(2'b00, 1, 3, 0, 0, 1, 1, 0);
        expect_frame(3*DS+1, 1, 1*DS+1, 1, -1);
        pulse_pin(4); settle(150);

        // R1 R9: host repeating; pin edge ignored; stop by dropping level in third frame
        cfg(2'b11, 1, 2, 0, 0, 0, 0, 3);
        base = frames;
        pulse_pin(4); settle(100);
        chk(frames == base, "R1 pin ignored in host mode", frames, base);
        expect_frame(2*DS+1, 1, 2*DS+1, 1, -1);
        expect_frame(2*DS+1, 1, 2*DS+1, 1, 3*DF + 1*DS + 3);
        expect_frame(2*DS+1, 1, 2*DS+1, 1, 3*DF + 1*DS + 3);
        @(posedge clk); #1 trig_host = 1'b1;
        wait (frames == base + 2);
        wait (integrate == 1'b1);
        #1 trig_host = 1'b0;
        settle(200);
        chk(frames == base + 3, "R9 repeat stops on low level", frames, base + 3);

        // R9: pin repeating with a short pulse gives a single frame
        cfg(2'b01, 1, 3, 0, 0, 0, 0, 2);
        expect_frame(3*DS+1, 1, 3*DS+1, 1, -1);
        base = frames;
        pulse_pin(3); settle(200);
        chk(frames == base + 1, "R9 short level single frame", frames, base + 1);

        chk(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);
        report();
    end
endmodule